// File: doc/BRIEF.md
# Transmit Descriptor Poll Engine

This block is the transmit half of a network controller's descriptor machinery. Software builds a ring of 16-byte descriptors in shared memory and programs the ring base. It fills in a descriptor, hands it to the hardware by setting its ownership bit, and then writes a poll command. The engine then walks the ring from its current position. For every descriptor the hardware owns, it fetches the frame bytes from the buffer the descriptor points to and sends them out on a byte stream. Frames shorter than the Ethernet minimum are padded with zero bytes. When a frame is finished, the engine clears the ownership bit in memory and raises a transmit-done flag.

Scanning stops at the first descriptor that software still owns. At that point the engine raises a descriptor-unavailable flag and waits for the next poll command. An end-of-ring mark in a descriptor sends the next fetch back to the ring base. Only single-buffer frames, with both the first-segment and last-segment marks set, are sent. Any other owned descriptor is handed back with an error flag and produces no bytes.

The host port holds three registers with a one-cycle registered read. The memory port is a 32-bit word port with a one-cycle read latency. The output stream uses valid/ready with a last marker.

Top module: `txd_poll_engine`

## Requirements
- R1: After reset the interrupt status register reads 0, the base register reads 0, `tx_valid` is low and the fetch pointer sits at address 0.
- R2: A host write to register 0 whose data has bit 6 set starts a scan at the current fetch pointer. A write to register 0 with bit 6 clear starts nothing, and the descriptor stays owned.
- R3: A descriptor is 16 bytes. The status word is at offset +0: bit 31 is hardware ownership, bit 30 is end-of-ring, bit 29 is first-segment, bit 28 is last-segment, and bits 12:0 are the frame length in bytes. The buffer address is at offset +8, and only its low ADDR_W bits are used. The words at +4 and +12 are ignored.
- R4: Frame bytes leave in ascending buffer address order, and the buffer may start at any byte alignment. The byte at address a is bits 8*(a mod 4)+7 down to 8*(a mod 4) of the memory word at a/4 (little-endian lanes).
- R5: A frame whose length is below 60 is followed by zero bytes up to 60 bytes in total. A length of 60 or more sends exactly that many bytes.
- R6: `tx_last` is high on the final byte of each frame and on no other byte.
- R7: While `tx_valid` is high and `tx_ready` is low, `tx_valid`, `tx_data` and `tx_last` hold their values.
- R8: After a frame is sent, the engine writes its status word back with bit 31 cleared and every other bit unchanged, and sets interrupt status bit 2 (transmit done).
- R9: A descriptor with bit 31 clear ends the scan. The engine sets interrupt status bit 7 (descriptor unavailable), writes nothing to that descriptor and emits nothing more.
- R10: After a descriptor with end-of-ring set, the next fetch is at the ring base. Otherwise the next fetch is 16 bytes further on.
- R11: An owned descriptor that lacks either the first-segment or the last-segment bit produces no stream bytes. The engine clears its ownership bit and sets interrupt status bit 3 (transmit error).
- R12: Register 2 holds interrupt status in bits 2, 3 and 7, and writing 1 to a bit clears it. Register 1 holds the ring base with bits 3:0 forced to 0, and writing it also moves the fetch pointer to it. Read data appears on `reg_rdata` the cycle after `reg_rd_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr_en | input | 1 | Host register write strobe |
| reg_rd_en | input | 1 | Host register read strobe |
| reg_addr | input | 2 | Register select: 0 poll, 1 ring base, 2 interrupt status |
| reg_wdata | input | 32 | Host write data |
| reg_rdata | output | 32 | Host read data, valid one cycle after the read strobe |
| mem_rd_en | output | 1 | Memory word read request |
| mem_we | output | 1 | Memory word write request |
| mem_addr | output | ADDR_W | Memory byte address, word aligned |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Memory read data, one cycle after the request |
| tx_data | output | 8 | Frame byte |
| tx_valid | output | 1 | Frame byte valid |
| tx_ready | input | 1 | Sink accepts the byte |
| tx_last | output | 1 | Final byte of the frame |

## Verification
The engine is driven with four kinds of descriptor. There is a 60-byte frame from an unaligned buffer, which separates the lane selection from the word fetch and tests the padding boundary. There is a 10-byte frame, which must be padded. There is a 61-byte frame behind a relocated ring base. Finally, there is a first-segment-only descriptor, which must complete silently with an error. The ring is laid out with a still-owned descriptor just past an end-of-ring mark, so a missed wrap shows up as extra stream bytes or a consumed descriptor. A poll write without its start bit is tried first; a scan started by mistake would consume the descriptor. Backpressure follows an irregular pattern throughout, so that hold behaviour and byte order are checked under stalls.

// File: rtl/txd_poll_pkg.sv
package txd_poll_pkg;
  localparam int OWN_B  = 31;
  localparam int EOR_B  = 30;
  localparam int FSEG_B = 29;
  localparam int LSEG_B = 28;
  localparam int DESC_BYTES = 16;
  localparam int BUF_OFS    = 8;
  localparam int KICK_B     = 6;
  localparam int IRQ_DONE_B = 2;
  localparam int IRQ_ERR_B  = 3;
  localparam int IRQ_DRY_B  = 7;
  localparam logic [1:0] REG_KICK = 2'd0;
  localparam logic [1:0] REG_RING = 2'd1;
  localparam logic [1:0] REG_IRQ  = 2'd2;

  typedef enum logic [3:0] {
    E_IDLE, E_ST_WAIT, E_ST_CAP, E_BA_WAIT, E_BA_CAP,
    E_SEND, E_WD_WAIT, E_WD_CAP, E_WB, E_NEXT
  } eng_state_t;
endpackage

// File: rtl/txd_host_regs.sv
module txd_host_regs
  import txd_poll_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr_en,
  input  logic              reg_rd_en,
  input  logic [1:0]        reg_addr,
  input  logic [31:0]       reg_wdata,
  input  logic              set_done,
  input  logic              set_err,
  input  logic              set_dry,
  output logic [31:0]       reg_rdata,
  output logic [ADDR_W-1:0] ring_base,
  output logic              ring_load,
  output logic              kick
);
  logic irq_done_q, irq_err_q, irq_dry_q;
  logic wr_irq;
  logic unused_wbits;

  assign wr_irq = reg_wr_en && (reg_addr == REG_IRQ);
  assign unused_wbits = ^reg_wdata;

  always_ff @(posedge clk) begin
    if (rst) begin
      ring_base  <= '0;
      ring_load  <= 1'b0;
      kick       <= 1'b0;
      irq_done_q <= 1'b0;
      irq_err_q  <= 1'b0;
      irq_dry_q  <= 1'b0;
      reg_rdata  <= '0;
    end else begin
      kick      <= reg_wr_en && (reg_addr == REG_KICK) && reg_wdata[KICK_B];
      ring_load <= reg_wr_en && (reg_addr == REG_RING);
      if (reg_wr_en && (reg_addr == REG_RING))
        ring_base <= {reg_wdata[ADDR_W-1:4], 4'b0000};
      irq_done_q <= set_done | (irq_done_q & ~(wr_irq & reg_wdata[IRQ_DONE_B]));
      irq_err_q  <= set_err  | (irq_err_q  & ~(wr_irq & reg_wdata[IRQ_ERR_B]));
      irq_dry_q  <= set_dry  | (irq_dry_q  & ~(wr_irq & reg_wdata[IRQ_DRY_B]));
      if (reg_rd_en) begin
        reg_rdata <= '0;
        case (reg_addr)
          REG_RING: reg_rdata[ADDR_W-1:0] <= ring_base;
          REG_IRQ: begin
            reg_rdata[IRQ_DONE_B] <= irq_done_q;
            reg_rdata[IRQ_ERR_B]  <= irq_err_q;
            reg_rdata[IRQ_DRY_B]  <= irq_dry_q;
          end
          default: reg_rdata <= '0;
        endcase
      end
    end
  end

  // R12
  irq_w1c_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_irq && reg_wdata[IRQ_DONE_B] && !set_done) |=> !irq_done_q);

  // R12
  irq_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (irq_dry_q && !wr_irq) |=> irq_dry_q);
endmodule

// File: rtl/txd_lane_pick.sv
module txd_lane_pick #(
  parameter int WORD_BYTES = 4,
  localparam int LANE_W = $clog2(WORD_BYTES)
) (
  input  logic [8*WORD_BYTES-1:0] word,
  input  logic [LANE_W-1:0]       lane,
  input  logic                    pad,
  output logic [7:0]              byte_o
);
  logic [7:0] lanes [WORD_BYTES];
  for (genvar g = 0; g < WORD_BYTES; g++) begin : g_lane
    assign lanes[g] = word[8*g +: 8];
  end
  assign byte_o = pad ? 8'h00 : lanes[lane];
endmodule

// File: rtl/txd_engine.sv
module txd_engine
  import txd_poll_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int LEN_W     = 13,
  parameter int MIN_FRAME = 60
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              kick,
  input  logic              ring_load,
  input  logic [ADDR_W-1:0] ring_base,
  output logic              mem_rd_en,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [31:0]       mem_wdata,
  input  logic [31:0]       mem_rdata,
  output logic [7:0]        tx_data,
  output logic              tx_valid,
  input  logic              tx_ready,
  output logic              tx_last,
  output logic              set_done,
  output logic              set_err,
  output logic              set_dry
);
  localparam logic [LEN_W-1:0] MIN_LEN = LEN_W'(MIN_FRAME);

  eng_state_t        state;
  logic [ADDR_W-1:0] cur_addr, buf_addr;
  logic [31:0]       status, word_buf;
  logic [LEN_W-1:0]  idx;
  logic              word_ok, is_err;

  logic [LEN_W-1:0]  len_f, total;
  logic [ADDR_W-1:0] byte_addr, byte_addr_nx;
  logic [7:0]        pick;
  logic              stalled;

  assign len_f        = status[LEN_W-1:0];
  assign total        = (len_f < MIN_LEN) ? MIN_LEN : len_f;
  assign byte_addr    = buf_addr + ADDR_W'(idx);
  assign byte_addr_nx = byte_addr + ADDR_W'(1);
  assign stalled      = tx_valid && !tx_ready;

  txd_lane_pick #(.WORD_BYTES(4)) lane_i (
    .word  (word_buf),
    .lane  (byte_addr[1:0]),
    .pad   (idx >= len_f),
    .byte_o(pick)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= E_IDLE;
      cur_addr  <= '0;
      buf_addr  <= '0;
      status    <= '0;
      word_buf  <= '0;
      idx       <= '0;
      word_ok   <= 1'b0;
      is_err    <= 1'b0;
      mem_rd_en <= 1'b0;
      mem_we    <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
      tx_data   <= '0;
      tx_valid  <= 1'b0;
      tx_last   <= 1'b0;
      set_done  <= 1'b0;
      set_err   <= 1'b0;
      set_dry   <= 1'b0;
    end else begin
      mem_rd_en <= 1'b0;
      mem_we    <= 1'b0;
      set_done  <= 1'b0;
      set_err   <= 1'b0;
      set_dry   <= 1'b0;
      if (ring_load) cur_addr <= ring_base;
      case (state)
        E_IDLE: begin
          if (kick) begin
            mem_rd_en <= 1'b1;
            mem_addr  <= cur_addr;
            state     <= E_ST_WAIT;
          end
        end
        E_ST_WAIT: state <= E_ST_CAP;
        E_ST_CAP: begin
          status <= mem_rdata;
          if (!mem_rdata[OWN_B]) begin
            set_dry <= 1'b1;
            state   <= E_IDLE;
          end else if (!(mem_rdata[FSEG_B] && mem_rdata[LSEG_B])) begin
            is_err <= 1'b1;
            state  <= E_WB;
          end else begin
            is_err    <= 1'b0;
            mem_rd_en <= 1'b1;
            mem_addr  <= cur_addr + ADDR_W'(BUF_OFS);
            state     <= E_BA_WAIT;
          end
        end
        E_BA_WAIT: state <= E_BA_CAP;
        E_BA_CAP: begin
          buf_addr <= mem_rdata[ADDR_W-1:0];
          idx      <= '0;
          word_ok  <= 1'b0;
          state    <= E_SEND;
        end
        E_SEND: begin
          if (tx_valid && tx_ready) begin
            tx_valid <= 1'b0;
            tx_last  <= 1'b0;
          end
          if (!stalled) begin
            if (idx == total) begin
              state <= E_WB;
            end else if ((idx < len_f) && !word_ok) begin
              mem_rd_en <= 1'b1;
              mem_addr  <= {byte_addr[ADDR_W-1:2], 2'b00};
              state     <= E_WD_WAIT;
            end else begin
              tx_data  <= pick;
              tx_valid <= 1'b1;
              tx_last  <= (idx == total - LEN_W'(1));
              idx      <= idx + LEN_W'(1);
              if (byte_addr_nx[1:0] == 2'b00) word_ok <= 1'b0;
            end
          end
        end
        E_WD_WAIT: state <= E_WD_CAP;
        E_WD_CAP: begin
          word_buf <= mem_rdata;
          word_ok  <= 1'b1;
          state    <= E_SEND;
        end
        E_WB: begin
          mem_we    <= 1'b1;
          mem_addr  <= cur_addr;
          mem_wdata <= status & ~(32'h1 << OWN_B);
          set_done  <= !is_err;
          set_err   <= is_err;
          cur_addr  <= status[EOR_B] ? ring_base : cur_addr + ADDR_W'(DESC_BYTES);
          state     <= E_NEXT;
        end
        E_NEXT: begin
          mem_rd_en <= 1'b1;
          mem_addr  <= cur_addr;
          state     <= E_ST_WAIT;
        end
        default: state <= E_IDLE;
      endcase
    end
  end

  // R7
  tx_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data) && $stable(tx_last)));

  // R8
  wb_own_chk: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> !mem_wdata[OWN_B]);

  // R6
  last_gap_chk: assert property (@(posedge clk) disable iff (rst)
    (tx_valid && tx_ready && tx_last) |=> !tx_valid);

  // R9
  dry_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    set_dry |-> (!tx_valid && !mem_we));

  // R8
  wb_no_pending_chk: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> !tx_valid);
endmodule

// File: rtl/txd_poll_engine.sv
module txd_poll_engine
  import txd_poll_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int LEN_W     = 13,
  parameter int MIN_FRAME = 60
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr_en,
  input  logic              reg_rd_en,
  input  logic [1:0]        reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              mem_rd_en,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [31:0]       mem_wdata,
  input  logic [31:0]       mem_rdata,
  output logic [7:0]        tx_data,
  output logic              tx_valid,
  input  logic              tx_ready,
  output logic              tx_last
);
  logic [ADDR_W-1:0] ring_base;
  logic ring_load, kick, set_done, set_err, set_dry;

  txd_host_regs #(.ADDR_W(ADDR_W)) regs_i (
    .clk(clk), .rst(rst),
    .reg_wr_en(reg_wr_en), .reg_rd_en(reg_rd_en), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata),
    .set_done(set_done), .set_err(set_err), .set_dry(set_dry),
    .reg_rdata(reg_rdata), .ring_base(ring_base), .ring_load(ring_load),
    .kick(kick)
  );

  txd_engine #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .MIN_FRAME(MIN_FRAME)) eng_i (
    .clk(clk), .rst(rst),
    .kick(kick), .ring_load(ring_load), .ring_base(ring_base),
    .mem_rd_en(mem_rd_en), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .tx_last(tx_last),
    .set_done(set_done), .set_err(set_err), .set_dry(set_dry)
  );
endmodule

// File: tb/txd_poll_engine_tb.sv
module txd_poll_engine_tb_top;
  localparam int ADDR_W = 16;
  localparam logic [31:0] OWN = 32'h8000_0000;
  localparam logic [31:0] EOR = 32'h4000_0000;
  localparam logic [31:0] FSG = 32'h2000_0000;
  localparam logic [31:0] LSG = 32'h1000_0000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic reg_wr_en = 1'b0, reg_rd_en = 1'b0;
  logic [1:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic mem_rd_en, mem_we;
  logic [ADDR_W-1:0] mem_addr;
  logic [31:0] mem_wdata;
  logic [31:0] mem_rdata = '0;
  logic [7:0] tx_data;
  logic tx_valid, tx_last;
  logic tx_ready = 1'b0;

  logic [31:0] mem [0:1023];
  logic [8:0] expq [$];
  int total = 0, bad = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  txd_poll_engine #(.ADDR_W(ADDR_W)) dut_i (
    .clk(clk), .rst(rst),
    .reg_wr_en(reg_wr_en), .reg_rd_en(reg_rd_en), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .mem_rd_en(mem_rd_en), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .tx_last(tx_last)
  );

  always @(posedge clk) begin
    if (mem_rd_en) mem_rdata <= mem[mem_addr[11:2]];
    if (mem_we) mem[mem_addr[11:2]] <= mem_wdata;
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  function automatic logic [7:0] mbyte(input int a);
    logic [31:0] w;
    w = mem[a >> 2];
    return w[8*(a % 4) +: 8];
  endfunction

  task automatic push_frame(input int buf_a, input int len);
    int tot;
    tot = (len < 60) ? 60 : len;
    for (int i = 0; i < tot; i++)
      expq.push_back({(i == tot - 1), (i < len) ? mbyte(buf_a + i) : 8'h00});
  endtask

  task automatic reg_write(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr_en = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr_en = 1'b0;
  endtask

  task automatic reg_read(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_rd_en = 1'b1; reg_addr = a;
    @(negedge clk);
    reg_rd_en = 1'b0;
    d = reg_rdata;
  endtask

  task automatic put_desc(input int a, input logic [31:0] st, input int buf_a);
    mem[a >> 2]         <= st;
    mem[(a >> 2) + 1]   <= 32'hDEAD_0001;
    mem[(a >> 2) + 2]   <= buf_a;
    mem[(a >> 2) + 3]   <= 32'hDEAD_0003;
    @(negedge clk);
  endtask

  task automatic wait_dry();
    logic [31:0] v;
    for (int i = 0; i < 3000; i++) begin
      reg_read(2'd2, v);
      if (v[7]) break;
    end
    repeat (4) @(negedge clk);
  endtask

  // scoreboard monitor; also checks hold under stall (R7)
  logic pv = 1'b0, pr = 1'b0, pl = 1'b0;
  logic [7:0] pd = '0;
  initial begin
    forever begin
      @(negedge clk);
      if (!rst) begin
        if (pv && !pr)
          check(tx_valid && tx_data == pd && tx_last == pl, "R7 hold under stall",
                {23'd0, tx_valid, tx_data}, {24'd1, pd});
        if (tx_valid && tx_ready) begin
          if (expq.size() == 0) begin
            check(1'b0, "R11/R2 unexpected byte", {23'd0, tx_last, tx_data}, 32'h0);
          end else begin
            logic [8:0] e;
            e = expq.pop_front();
            check(tx_data == e[7:0], "R4/R5 byte value", {24'd0, tx_data}, {24'd0, e[7:0]});
            check(tx_last == e[8], "R6 last flag", {31'd0, tx_last}, {31'd0, e[8]});
          end
        end
      end
      pv = tx_valid; pr = tx_ready; pd = tx_data; pl = tx_last;
    end
  end

  initial begin
    int cnt = 0;
    forever begin
      @(posedge clk);
      #1;
      cnt++;
      tx_ready = ((cnt % 7) != 2) && ((cnt % 5) != 0);
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    check(1'b0, "watchdog", 32'h0, 32'h1);
    summary();
  end

  initial begin
    logic [31:0] v;
    for (int i = 0; i < 1024; i++) mem[i] = (i * 32'h0104_0A11) ^ 32'h5A3C_96E1;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1
    check(tx_valid == 1'b0, "R1 tx_valid after reset", {31'd0, tx_valid}, 32'h0);
    reg_read(2'd2, v);
    check(v == 32'h0, "R1 irq after reset", v, 32'h0);
    reg_read(2'd1, v);
    check(v == 32'h0, "R1 base after reset", v, 32'h0);

    // ring at 0: 60-byte unaligned, 10-byte with end-of-ring, owned decoy at 0x20
    put_desc(32'h000, OWN | FSG | LSG | 32'd60, 32'h203);
    put_desc(32'h010, OWN | EOR | FSG | LSG | 32'd10, 32'h400);
    put_desc(32'h020, OWN | FSG | LSG | 32'd70, 32'h500);

    // R2: no start bit
    reg_write(2'd0, 32'h0000_00BF);
    repeat (40) @(negedge clk);
    check(mem[0][31] == 1'b1, "R2 write without bit 6 ignored", mem[0], OWN);

    // R2/R3/R4/R5/R10
    push_frame(32'h203, 60);
    push_frame(32'h400, 10);
    reg_write(2'd0, 32'h0000_0040);
    wait_dry();
    check(expq.size() == 0, "R4 all bytes delivered", expq.size(), 32'h0);
    check(mem[0] == (FSG | LSG | 32'd60), "R8 writeback desc0", mem[0], FSG | LSG | 32'd60);
    check(mem[4] == (EOR | FSG | LSG | 32'd10), "R8 writeback desc1", mem[4], EOR | FSG | LSG | 32'd10);
    check(mem[8][31] == 1'b1, "R10 wrap skips desc after end-of-ring", mem[8], OWN);
    check(mem[1] == 32'hDEAD_0001, "R3 vlan word untouched", mem[1], 32'hDEAD_0001);
    reg_read(2'd2, v);
    check(v == 32'h84, "R8/R9 irq after frames", v, 32'h84);

    // R12 write-one-to-clear
    reg_write(2'd2, 32'h0000_0004);
    reg_read(2'd2, v);
    check(v == 32'h80, "R12 clear done bit only", v, 32'h80);
    reg_write(2'd2, 32'h0000_0080);
    reg_read(2'd2, v);
    check(v == 32'h0, "R12 clear unavailable bit", v, 32'h0);

    // R11: first segment only; R9 on desc1 (owner software)
    put_desc(32'h000, OWN | FSG | 32'd60, 32'h203);
    reg_write(2'd0, 32'h0000_0040);
    wait_dry();
    check(mem[0] == (FSG | 32'd60), "R11 error desc handed back", mem[0], FSG | 32'd60);
    check(mem[4] == (EOR | FSG | LSG | 32'd10), "R9 unowned desc not written", mem[4], EOR | FSG | LSG | 32'd10);
    reg_read(2'd2, v);
    check(v == 32'h88, "R11 irq error and unavailable", v, 32'h88);
    reg_write(2'd2, 32'hFFFF_FFFF);

    // R12 base relocation, R10 wrap to new base, R5 length 61
    reg_write(2'd1, 32'h0000_010F);
    reg_read(2'd1, v);
    check(v == 32'h100, "R12 base low bits forced zero", v, 32'h100);
    put_desc(32'h100, OWN | EOR | FSG | LSG | 32'd61, 32'h602);
    put_desc(32'h110, OWN | FSG | LSG | 32'd64, 32'h700);
    push_frame(32'h602, 61);
    reg_write(2'd0, 32'hFFFF_FFFF);
    wait_dry();
    check(expq.size() == 0, "R5 61-byte frame delivered", expq.size(), 32'h0);
    check(mem[32'h100 >> 2] == (EOR | FSG | LSG | 32'd61), "R8 writeback relocated",
          mem[32'h100 >> 2], EOR | FSG | LSG | 32'd61);
    check(mem[32'h110 >> 2][31] == 1'b1, "R10 wrap to relocated base", mem[32'h110 >> 2], OWN);
    reg_read(2'd2, v);
    check(v == 32'h84, "R9 irq after relocated ring", v, 32'h84);

    summary();
  end
endmodule